// File: doc/BRIEF.md
# Per-Core One-Shot Event Timer Bank

This block serves a small multi-core processor. It holds one free-running tick counter that every core can read, and one one-shot event timer per core. A core arms its timer by writing a relative tick count. After that many clock ticks the timer raises a level interrupt on that core's own line. The line stays high until software clears it, and the timer does not re-arm by itself.

Each core reaches its timer through a private register port made of a 2-bit address, a write strobe, write data and registered read data. The port decodes four registers:

| Address | Register | Contents |
|---|---|---|
| 3 | Counter view | Read-only view of the shared counter |
| 2 | Delay | Write: delta. Read: ticks remaining |
| 1 | Pending flag | Bit 0 |
| 0 | Enable | Bit 0 |

The number of cores and the counter width are parameters. The width defaults to 32 bits.

Top module: `ptimer_bank`

## Requirements
- R1: The shared counter resets to 0 and increases by exactly one on every clock. It reads (address 3) with the same value on every core's port. Read data appears one clock after the address is presented and shows the state before that clock edge.
- R2: The shared counter wraps from 2^CNT_W-1 to 0 and keeps counting.
- R3: With the timer enabled, a write of delta D (D at least 2) to the delay register (address 2) raises that core's `irq` bit exactly D clocks after the write edge.
- R4: Deltas 0 and 1 are treated as 2. The largest value 2^CNT_W-1 is accepted. Reading the delay register returns the remaining tick count.
- R5: Writing bit 0 = 1 to the enable register (address 0) runs the countdown. Writing bit 0 = 0 freezes it with the remaining count kept, and no event fires while it is frozen. Re-enabling resumes from the kept count.
- R6: A delta written while the timer is disabled is held. It fires D clocks after the timer is then enabled.
- R7: Writing the delay register while a countdown is running restarts the countdown from the new delta.
- R8: The event is one-shot. Once the countdown reaches 0 it stays at 0 and no further event fires without a new delta.
- R9: Writing the pending-flag register (address 1) with bit 0 = 0 drops `irq` at the write edge. A write with bit 0 = 1 has no effect. An expiry on the same edge as a clear leaves the flag set. The flag reads back as bit 0.
- R10: Each core's timer and `irq` bit work independently of the other cores.
- R11: Reset clears all enable, pending and delay state and the shared counter, and drives all read data and `irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock for the counter and all timers |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2*NUM_CORES | Register select per core, core c at bits [2c+1:2c] |
| reg_we | input | NUM_CORES | Write strobe per core |
| reg_wdata | input | CNT_W*NUM_CORES | Write data per core |
| reg_rdata | output | CNT_W*NUM_CORES | Registered read data per core |
| irq | output | NUM_CORES | Level interrupt per core |

## Verification
A table of deltas is applied round-robin across the cores. It includes 0 and 1 (clamped), 2 and 3 (the shortest real waits) and longer values, and for each the bench counts the clocks from the write edge to the interrupt. This separates an off-by-one in the countdown from a missing clamp. Directed sequences then cover the following:
- a pause in mid-countdown followed by a resume, which tells freezing apart from clearing;
- a delta parked while disabled;
- a reload in mid-flight, which tells restart apart from accumulation;
- a clear that lands on the expiry edge;
- two cores with overlapping deadlines.

A second instance with an 8-bit counter shows the wrap.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  // Register select codes on each core's port
  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_PENDING = 2'd1,
    SEL_DELAY   = 2'd2,
    SEL_TICKS   = 2'd3
  } ptb_sel_e;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned MIN_DELTA = 2;

endpackage

// File: rtl/ptb_tick_counter.sv
module ptb_tick_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] ticks
);

  always_ff @(posedge clk) begin
    if (rst) ticks <= '0;
    else     ticks <= ticks + CNT_W'(1);
  end

  // R1 / R2: one step per clock, modulo 2^CNT_W
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ticks == CNT_W'($past(ticks) + CNT_W'(1)));

endmodule

// File: rtl/ptb_read_port.sv
module ptb_read_port #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ptb_pkg::SEL_W-1:0] sel,
  input  logic                     enable_q,
  input  logic                     pending_q,
  input  logic [CNT_W-1:0]         remain_q,
  input  logic [CNT_W-1:0]         ticks,
  output logic [CNT_W-1:0]         rdata
);
  import ptb_pkg::*;

  logic [CNT_W-1:0] mux_d;

  always_comb begin
    unique case (ptb_sel_e'(sel))
      SEL_ENABLE:  mux_d = {{(CNT_W-1){1'b0}}, enable_q};
      SEL_PENDING: mux_d = {{(CNT_W-1){1'b0}}, pending_q};
      SEL_DELAY:   mux_d = remain_q;
      default:     mux_d = ticks;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux_d;
  end

endmodule

// File: rtl/ptb_core_timer.sv
module ptb_core_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ptb_pkg::SEL_W-1:0] sel,
  input  logic                      we,
  input  logic [CNT_W-1:0]          wdata,
  input  logic [CNT_W-1:0]          ticks,
  output logic [CNT_W-1:0]          rdata,
  output logic                      irq
);
  import ptb_pkg::*;

  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_DELTA);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic             enable_q;
  logic             pending_q;
  logic [CNT_W-1:0] remain_q;

  logic             wr_enable, wr_pending, wr_delay;
  logic             expire;
  logic [CNT_W-1:0] delta_in;

  always_comb begin
    wr_enable  = we && (ptb_sel_e'(sel) == SEL_ENABLE);
    wr_pending = we && (ptb_sel_e'(sel) == SEL_PENDING);
    wr_delay   = we && (ptb_sel_e'(sel) == SEL_DELAY);
    delta_in   = (wdata < FLOOR) ? FLOOR : wdata;
    expire     = enable_q && (remain_q == ONE) && !wr_delay;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
    end else if (wr_enable) begin
      enable_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (wr_delay) begin
      remain_q <= delta_in;
    end else if (enable_q && remain_q != '0) begin
      remain_q <= remain_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
    end else if (expire) begin
      pending_q <= 1'b1;
    end else if (wr_pending && !wdata[0]) begin
      pending_q <= 1'b0;
    end
  end

  assign irq = pending_q;

  ptb_read_port #(.CNT_W(CNT_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .enable_q  (enable_q),
    .pending_q (pending_q),
    .remain_q  (remain_q),
    .ticks     (ticks),
    .rdata     (rdata)
  );

  // R3 / R9: last tick sets the flag, even against a clear on that edge
  p_fire_r3: assert property (@(posedge clk) disable iff (rst)
    (enable_q && remain_q == ONE && !wr_delay) |=> irq);

  // R4: a freshly loaded countdown never starts below the floor
  p_floor_r4: assert property (@(posedge clk) disable iff (rst)
    wr_delay |=> remain_q >= FLOOR);

  // R5: frozen countdown holds its value
  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (!enable_q && !wr_delay) |=> $stable(remain_q));

  // R8: an exhausted countdown cannot raise a new event
  p_oneshot_r8: assert property (@(posedge clk) disable iff (rst)
    (remain_q == '0 && !irq) |=> !irq);

  // R9: the flag holds until a clearing write
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !(wr_pending && !wdata[0])) |=> irq);

endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned CNT_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ptb_pkg::SEL_W*NUM_CORES-1:0] reg_addr,
  input  logic [NUM_CORES-1:0]              reg_we,
  input  logic [CNT_W*NUM_CORES-1:0]        reg_wdata,
  output logic [CNT_W*NUM_CORES-1:0]        reg_rdata,
  output logic [NUM_CORES-1:0]              irq
);
  import ptb_pkg::*;

  logic [CNT_W-1:0] ticks;

  ptb_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ticks (ticks)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ptb_core_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .sel   (reg_addr[c*SEL_W +: SEL_W]),
      .we    (reg_we[c]),
      .wdata (reg_wdata[c*CNT_W +: CNT_W]),
      .ticks (ticks),
      .rdata (reg_rdata[c*CNT_W +: CNT_W]),
      .irq   (irq[c])
    );
  end

  // R11: interrupts are quiet in the cycle after reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> irq == '0);

endmodule

// File: tb/ptimer_bank_test.sv
module ptimer_bank_test;

  localparam int NC = 4;
  localparam int W  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2*NC-1:0]   reg_addr  = '0;
  logic [NC-1:0]     reg_we    = '0;
  logic [W*NC-1:0]   reg_wdata = '0;
  logic [W*NC-1:0]   reg_rdata;
  logic [NC-1:0]     irq;

  logic [1:0] n_addr  = 2'd3;
  logic       n_we    = 1'b0;
  logic [7:0] n_wdata = '0;
  logic [7:0] n_rdata;
  logic       n_irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ptimer_bank #(.NUM_CORES(NC), .CNT_W(W)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  ptimer_bank #(.NUM_CORES(1), .CNT_W(8)) u_narrow (
    .clk(clk), .rst(rst), .reg_addr(n_addr), .reg_we(n_we),
    .reg_wdata(n_wdata), .reg_rdata(n_rdata), .irq(n_irq)
  );

  localparam int unsigned VEC_D [8] = '{0, 1, 2, 3, 5, 17, 64, 100};
  localparam int unsigned VEC_E [8] = '{2, 2, 2, 3, 5, 17, 64, 100};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr[c*2 +: 2]  = a;
    reg_wdata[c*W +: W] = d;
    reg_we[c]           = 1'b1;
    @(negedge clk);
    reg_we[c]           = 1'b0;
  endtask

  task automatic rd(input int c, input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr[c*2 +: 2] = a;
    @(negedge clk);
    v = reg_rdata[c*W +: W];
  endtask

  task automatic wait_irq(input int c, input int limit, output int n);
    n = 0;
    while (!irq[c] && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a0, a1, b0;
    logic [7:0]  nv1, nv2;
    int n, m;

    // R11: state while reset is held
    repeat (3) @(negedge clk);
    check("R11 irq in reset", 32'(irq), 0);
    check("R11 rdata in reset", reg_rdata[31:0], 0);
    @(negedge clk) rst = 1'b0;
    rd(2, 2'd0, v); check("R11 enable after reset", v, 0);
    rd(2, 2'd1, v); check("R11 pending after reset", v, 0);
    rd(2, 2'd2, v); check("R11 delay after reset", v, 0);

    // R1: shared counter equal on two ports and advancing one per clock
    @(negedge clk); reg_addr[1:0] = 2'd3; reg_addr[3:2] = 2'd3;
    @(negedge clk); a0 = reg_rdata[31:0]; a1 = reg_rdata[63:32];
    check("R1 same view on cores 0 and 1", a1, a0);
    repeat (40) @(negedge clk);
    b0 = reg_rdata[31:0];
    check("R1 counter advance over 40 clocks", b0 - a0, 40);

    // R2: narrow instance wraps modulo 256
    @(negedge clk); nv1 = n_rdata;
    repeat (300) @(negedge clk);
    nv2 = n_rdata;
    check("R2 narrow counter wrap", 32'(nv2), 32'(8'(nv1 + 8'd44)));

    // enable every core
    for (int c = 0; c < NC; c++) wr(c, 2'd0, 32'd1);

    // R3 / R4: table of deltas, round-robin over cores
    for (int i = 0; i < 8; i++) begin
      int c;
      c = i % NC;
      wr(c, 2'd2, VEC_D[i]);
      wait_irq(c, 400, n);
      check($sformatf("R3 R4 delta %0d latency", VEC_D[i]), n, VEC_E[i]);
      wr(c, 2'd1, 32'd0);
      check("R9 clear drops irq", 32'(irq[c]), 0);
    end

    // R9: write of 1 ignored, flag readable, clear works
    wr(0, 2'd2, 32'd4);
    wait_irq(0, 100, n);
    wr(0, 2'd1, 32'd1);
    check("R9 write of 1 keeps irq", 32'(irq[0]), 1);
    rd(0, 2'd1, v); check("R9 pending reads 1", v, 1);
    wr(0, 2'd1, 32'd0);
    check("R9 clear", 32'(irq[0]), 0);

    // R8: no re-fire after expiry
    repeat (20) @(negedge clk);
    check("R8 no second event", 32'(irq[0]), 0);
    rd(0, 2'd2, v); check("R8 countdown parked at 0", v, 0);

    // R9: clear on the expiry edge loses to the expiry
    wr(1, 2'd2, 32'd2);
    wr(1, 2'd1, 32'd0);
    check("R9 expiry wins over same-edge clear", 32'(irq[1]), 1);
    wr(1, 2'd1, 32'd0);

    // R5: freeze and resume
    wr(2, 2'd2, 32'd10);
    repeat (4) @(negedge clk);
    wr(2, 2'd0, 32'd0);
    repeat (30) @(negedge clk);
    check("R5 no event while frozen", 32'(irq[2]), 0);
    rd(2, 2'd2, v); check("R5 remaining kept", v, 4);
    wr(2, 2'd0, 32'd1);
    wait_irq(2, 100, n);
    check("R5 resume latency", n, 4);
    wr(2, 2'd1, 32'd0);

    // R6: delta parked while disabled
    wr(2, 2'd0, 32'd0);
    wr(2, 2'd2, 32'd7);
    repeat (20) @(negedge clk);
    check("R6 no event while disabled", 32'(irq[2]), 0);
    wr(2, 2'd0, 32'd1);
    wait_irq(2, 100, n);
    check("R6 latency from enable", n, 7);
    wr(2, 2'd1, 32'd0);

    // R7: reload while running
    wr(2, 2'd2, 32'd50);
    repeat (10) @(negedge clk);
    wr(2, 2'd2, 32'd8);
    wait_irq(2, 100, n);
    check("R7 restart latency", n, 8);
    wr(2, 2'd1, 32'd0);

    // R10: two cores with overlapping deadlines
    wr(1, 2'd2, 32'd20);
    wr(0, 2'd2, 32'd10);
    wait_irq(0, 100, n);
    check("R10 core0 latency", n, 10);
    check("R10 core1 still quiet", 32'(irq[1]), 0);
    wait_irq(1, 100, m);
    check("R10 core1 fires later", m, 8);
    wr(0, 2'd1, 32'd0);
    wr(1, 2'd1, 32'd0);

    // R4: full-range delta accepted
    wr(3, 2'd2, 32'hFFFF_FFFF);
    rd(3, 2'd2, v);
    check("R4 max delta remaining", v, 32'hFFFF_FFFE);
    check("R4 max delta no event", 32'(irq[3]), 0);

    // R11: reset in mid-operation
    wr(3, 2'd2, 32'd3);
    wait_irq(3, 100, n);
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 irq cleared by reset", 32'(irq), 0);
    rst = 1'b0;
    rd(3, 2'd3, v); check("R11 counter restarts", v, 1);
    rd(3, 2'd0, v); check("R11 enable cleared", v, 0);
    rd(3, 2'd2, v); check("R11 delay cleared", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule